// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full Flag

This block is a first-in/first-out buffer for 9-bit words, which leaves room for a parity or control bit next to each data byte. A parameter sets the depth to 256, 512 or 1024 words. Two internal ring pointers choose where each word is stored and where it is fetched, so the block has no address inputs. Three active-low status outputs report Empty, Full and Half-Full. The block stops a write when it is full and stops a read when it is empty.

All control inputs are active-low levels sampled on the rising edge of one system clock. Each edge at which the write strobe is low stores one word, and each edge at which the read strobe is low fetches one word. A read and a write in the same cycle are allowed. The retransmit input rewinds the read pointer to location zero so that the stored data can be sent again from the first word. The write pointer does not move on a retransmit. Read data comes from a register and holds its value between reads.

Top module: `retx_fifo`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it, `empty_no`=0, `full_no`=1, `half_no`=1 and `rdata_o`=0.
- R2: Words are read back in the order they were written, with all 9 bits intact. The data appears on `rdata_o` after the clock edge at which `rd_ni` is low.
- R3: Once `DEPTH` words are held, `full_no`=0. A write strobe alone while full stores nothing and leaves the stored contents unchanged.
- R4: A read strobe alone while empty is ignored. `rdata_o` keeps its value and `empty_no` stays 0.
- R5: `half_no` is 0 while the word count is greater than `DEPTH/2`, and 1 while the count is `DEPTH/2` or less.
- R6: A clock edge with `rt_ni`=0 sets the read pointer back to location 0 and takes priority over a read in the same cycle. The next read returns the first word written since reset, and the flags follow the new distance to the unchanged write pointer.
- R7: A read and a write in the same cycle, when the buffer is neither empty nor full, leave the count and the flags unchanged.
- R8: A read and a write in the same cycle while empty perform only the write. The same pair while full performs only the read.
- R9: `rdata_o` changes only at an edge where a read is performed.
- R10: Both pointers wrap past the end of storage, and data order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| rt_ni | input | 1 | Retransmit, active low |
| wdata_i | input | 9 | Write data |
| rdata_o | output | 9 | Registered read data |
| empty_no | output | 1 | Empty flag, active low |
| full_no | output | 1 | Full flag, active low |
| half_no | output | 1 | Half-Full flag, active low |

## Verification
The assertions assume that all strobes are synchronous to `clk_i` and hold steady around its rising edge. They also assume that a retransmit is issued only while no more than `DEPTH` words have been written since reset; beyond that, rewinding to location 0 has no defined meaning. The bench changes its inputs a quarter period after each rising edge. It issues its single retransmit after only a handful of writes since reset, and every other sequence starts from a fresh reset.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/retx_ring_ptr.sv
module retx_ring_ptr #(
  parameter int unsigned PW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          rewind_i,
  output logic [PW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_o <= '0;
    else if (rewind_i) ptr_o <= '0;
    else if (adv_i)    ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/retx_store.sv
module retx_store
  import retx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output word_t         rdata_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/retx_flags.sv
module retx_flags #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PW = $clog2(DEPTH) + 1
) (
  input  logic [PW-1:0] wptr_i,
  input  logic [PW-1:0] rptr_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [PW-1:0] cnt;

  // extra pointer bit makes the difference an exact fill count
  assign cnt     = wptr_i - rptr_i;
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == FULL_CNT);
  assign half_o  = (cnt > HALF_CNT);
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              rt_ni,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              full_no,
  output logic              half_no
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wptr, rptr;
  logic          empty, full, half;
  logic          wr_en, rd_en, rewind;

  assign rewind = ~rt_ni;
  assign rd_en  = ~rd_ni & ~empty & ~rewind;
  assign wr_en  = ~wr_ni & ~full;

  retx_ring_ptr #(.PW(PW)) u_wptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (wr_en),
    .rewind_i (1'b0),
    .ptr_o    (wptr)
  );

  retx_ring_ptr #(.PW(PW)) u_rptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (rd_en),
    .rewind_i (rewind),
    .ptr_o    (rptr)
  );

  retx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wptr[AW-1:0]),
    .wdata_i (wdata_i),
    .re_i    (rd_en),
    .raddr_i (rptr[AW-1:0]),
    .rdata_o (rdata_o)
  );

  retx_flags #(.DEPTH(DEPTH)) u_flags (
    .wptr_i  (wptr),
    .rptr_i  (rptr),
    .empty_o (empty),
    .full_o  (full),
    .half_o  (half)
  );

  assign empty_no = ~empty;
  assign full_no  = ~full;
  assign half_no  = ~half;
endmodule

// File: rtl/retx_fifo_chk.sv
module retx_fifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_ni,
  input logic       rd_ni,
  input logic       rt_ni,
  input logic [8:0] rdata_o,
  input logic       empty_no,
  input logic       full_no,
  input logic       half_no
);
  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && !wr_ni && rd_ni && rt_ni) |=> !full_no);

  // R4
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_no && !rd_ni && wr_ni && rt_ni) |=> (!empty_no && $stable(rdata_o)));

  // R5
  half_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_no |-> empty_no);

  // R5
  full_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !half_no);

  // R8
  empty_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_no && !wr_ni && !rd_ni && rt_ni) |=> (empty_no && $stable(rdata_o)));

  // R8
  full_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && !wr_ni && !rd_ni && rt_ni) |=> full_no);

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni || !rt_ni) |=> $stable(rdata_o));

  // R1
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!empty_no && !full_no));
endmodule

bind retx_fifo retx_fifo_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_ni    (wr_ni),
  .rd_ni    (rd_ni),
  .rt_ni    (rt_ni),
  .rdata_o  (rdata_o),
  .empty_no (empty_no),
  .full_no  (full_no),
  .half_no  (half_no)
);

// File: tb/retx_fifo_tb.sv
`timescale 1ns/1ps
module retx_fifo_tb;
  localparam int unsigned DEPTH = 256;
  localparam int unsigned NVEC  = 13;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_ni = 1'b1, rd_ni = 1'b1, rt_ni = 1'b1;
  logic [8:0] wdata_i = '0;
  logic [8:0] rdata_o;
  logic       empty_no, full_no, half_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  retx_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ni    (wr_ni),
    .rd_ni    (rd_ni),
    .rt_ni    (rt_ni),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .empty_no (empty_no),
    .full_no  (full_no),
    .half_no  (half_no)
  );

  // {wr_n, rd_n, rt_n, wdata, exp_rdata, exp_empty_n, exp_full_n, exp_half_n}
  localparam logic [23:0] VEC [NVEC] = '{
    {3'b011, 9'h101, 9'h000, 3'b111},
    {3'b011, 9'h0A5, 9'h000, 3'b111},
    {3'b011, 9'h1FF, 9'h000, 3'b111},
    {3'b101, 9'h000, 9'h101, 3'b111},
    {3'b111, 9'h000, 9'h101, 3'b111},
    {3'b001, 9'h033, 9'h0A5, 3'b111},
    {3'b101, 9'h000, 9'h1FF, 3'b111},
    {3'b101, 9'h000, 9'h033, 3'b011},
    {3'b101, 9'h000, 9'h033, 3'b011},
    {3'b001, 9'h155, 9'h033, 3'b111},
    {3'b110, 9'h000, 9'h033, 3'b111},
    {3'b101, 9'h000, 9'h101, 3'b111},
    {3'b101, 9'h000, 9'h0A5, 3'b111}
  };
  string vtag [NVEC] = '{"R2", "R2", "R2", "R2", "R9", "R7", "R2",
                         "R2", "R4", "R8", "R6", "R6", "R6"};

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got rdata/e/f/h=%h expected %h", tag, act, exp);
    end
  endtask

  // drive, take one rising edge, sample a quarter period later
  task automatic cyc(input logic w, input logic r, input logic t, input logic [8:0] d);
    wr_ni = w; rd_ni = r; rt_ni = t; wdata_i = d;
    @(posedge clk_i);
    #5;
    wr_ni = 1'b1; rd_ni = 1'b1; rt_ni = 1'b1;
  endtask

  function automatic logic [11:0] outs();
    return {rdata_o, empty_no, full_no, half_no};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    #3;
    chk("R1", outs(), {9'h000, 3'b011});
    @(posedge clk_i);
    #5;
    rst_ni = 1'b1;
    @(posedge clk_i);
    #5;
    chk("R1", outs(), {9'h000, 3'b011});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    do_reset();

    for (int i = 0; i < int'(NVEC); i++) begin
      cyc(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:12]);
      chk(vtag[i], outs(), VEC[i][11:0]);
    end

    // fill: half boundary R5, full R3
    do_reset();
    for (int i = 0; i < int'(DEPTH); i++) begin
      cyc(1'b0, 1'b1, 1'b1, 9'(i));
      if (i + 1 == int'(DEPTH / 2))     chk("R5", {9'h0, empty_no, full_no, half_no}, {9'h0, 3'b111});
      if (i + 1 == int'(DEPTH / 2) + 1) chk("R5", {9'h0, empty_no, full_no, half_no}, {9'h0, 3'b110});
    end
    chk("R3", outs(), {9'h000, 3'b100});
    cyc(1'b0, 1'b1, 1'b1, 9'h1C3);                  // R3 write while full dropped
    chk("R3", outs(), {9'h000, 3'b100});
    cyc(1'b0, 1'b0, 1'b1, 9'h1AA);                  // R8 only the read happens
    chk("R8", outs(), {9'h000, 3'b110});
    cyc(1'b0, 1'b1, 1'b1, 9'h1BB);                  // R10 write pointer wraps
    chk("R10", outs(), {9'h000, 3'b100});
    for (int i = 1; i < int'(DEPTH); i++) begin
      cyc(1'b1, 1'b0, 1'b1, 9'h0);
      chk("R10", {rdata_o, 3'b000}, {9'(i), 3'b000});
    end
    cyc(1'b1, 1'b0, 1'b1, 9'h0);
    chk("R3", outs(), {9'h1BB, 3'b011});
    cyc(1'b1, 1'b0, 1'b1, 9'h0);                    // R4 underflow blocked
    chk("R4", outs(), {9'h1BB, 3'b011});

    // half drop back at exactly DEPTH/2 after a retransmit-free drain, R5
    do_reset();
    for (int i = 0; i <= int'(DEPTH / 2); i++) cyc(1'b0, 1'b1, 1'b1, 9'(i + 7));
    chk("R5", {9'h0, empty_no, full_no, half_no}, {9'h0, 3'b110});
    cyc(1'b1, 1'b0, 1'b1, 9'h0);
    chk("R5", outs(), {9'h007, 3'b111});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule